// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block gathers device-side USB events into two 8-bit status registers, each paired with an 8-bit enable register. It drives one active-high interrupt line. Event sources elsewhere in the controller feed it single-cycle pulses. These cover setup packet arrival, DMA completion, start-of-frame, root-port reset change, resume, suspend-state change, VBUS change and control status token. Endpoint summaries, the virtual endpoint summary, the reset condition and the suspend request arrive as levels.

Software reaches the four registers through a small 2-bit-addressed port with combinational read data. Latched bits are cleared by writing 1 to them. The live bits are not writable. Writing 1 to the suspend bit does not clear it. That write instead issues a one-cycle request to enter low-power suspend. Status bits record events whatever their enable bits hold. The enables only gate which recorded bits reach the interrupt line.

Top module: `devirq_ctrl`

## Requirements
- R1: Status register 0 (address 0) records setup packet in bit 5, DMA done in bit 6 and start-of-frame in bit 7. Each bit is set in the cycle after its input pulse, whatever the enable bits hold.
- R2: Status register 0 bits 0 to 3 show the endpoint 0, A, B and C summary levels (`ep_sum_i[0]` to `ep_sum_i[3]`), and bit 4 shows the virtual endpoint level. Writes to address 0 have no effect on these bits.
- R3: Writing a byte to a status register clears every latched bit written as 1. Latched bits written as 0 keep their value.
- R4: If an event pulse arrives in the same cycle as a write of 1 to its bit, the bit ends up set.
- R5: Status register 1 (address 1) bit 7 reads 1 exactly while `rst_pin_i` or `port_rst_active_i` is high. Writes do not change it.
- R6: Status register 1 records port reset change in bit 6, resume in bit 5, suspend-state change in bit 4, VBUS change in bit 2 and control status token in bit 1. Each bit is set in the cycle after its input pulse, whatever the enable bits hold.
- R7: Status register 1 bit 3 shows the live suspend request level, and bit 0 always reads 0. Writing 1 to bit 3 leaves that bit unchanged and raises `susp_enter_o` for exactly the one cycle after the write.
- R8: Enable registers at address 2 (for status 0) and address 3 (for status 1) read back the last byte written to them.
- R9: `irq_o` is high exactly when some status bit and its enable bit at the same position are both 1, across both registers.
- R10: After reset, all latched status bits, both enable registers and `susp_enter_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status 0, 1 status 1, 2 enable 0, 3 enable 1 |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| ep_sum_i | input | 4 | Endpoint 0, A, B, C summary levels |
| virt_ep_i | input | 1 | Virtual endpoint summary level |
| setup_pkt_i | input | 1 | Setup packet pulse |
| dma_done_i | input | 1 | DMA done pulse |
| sof_i | input | 1 | Start-of-frame pulse |
| port_rst_chg_i | input | 1 | Root-port reset detector change pulse |
| resume_i | input | 1 | Resume pulse |
| susp_chg_i | input | 1 | Suspend request state change pulse |
| vbus_chg_i | input | 1 | VBUS change pulse |
| ctl_status_i | input | 1 | Control status stage token pulse |
| rst_pin_i | input | 1 | Reset pin level |
| port_rst_active_i | input | 1 | Root-port reset active level |
| susp_req_i | input | 1 | Suspend request level |
| irq_o | output | 1 | Interrupt output |
| susp_enter_o | output | 1 | One-cycle suspend entry request |

## Verification
A corrupted latch or enable flop shows directly in the read data of its register. It also shows on `irq_o` in the cycle after the fault, once the matching enable is set. For that reason the bench sweeps every enable pattern against fixed status patterns. Mis-decoded write strobes would clear bits that should survive a 0 write, or a live bit, or the suspend bit. Each of these is read back in the cycle after the write. An event lost to a simultaneous clear would leave its bit at 0 on the next read.

// File: rtl/devirq_pkg.sv
package devirq_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int EP_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT0 = 2'd0,
        SEL_STAT1 = 2'd1,
        SEL_EN0   = 2'd2,
        SEL_EN1   = 2'd3
    } reg_sel_e;

    // status 0 bit positions
    localparam int S0_VIRT  = 4;
    localparam int S0_SETUP = 5;
    localparam int S0_DMA   = 6;
    localparam int S0_SOF   = 7;

    // status 1 bit positions
    localparam int S1_CTL   = 1;
    localparam int S1_VBUS  = 2;
    localparam int S1_SUSP  = 3;
    localparam int S1_SCHG  = 4;
    localparam int S1_RES   = 5;
    localparam int S1_PRST  = 6;
    localparam int S1_LIVE  = 7;

    localparam logic [REG_W-1:0] S0_LATCH_MASK = 8'hE0;
    localparam logic [REG_W-1:0] S1_LATCH_MASK = 8'h76;

    typedef struct packed {
        logic [REG_W-1:0] en0;
        logic [REG_W-1:0] en1;
    } en_regs_t;
endpackage

// File: rtl/devirq_latch_bank.sv
module devirq_latch_bank #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bits = ((st_q.bits & ~clr_i) | set_i) & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    for (genvar i = 0; i < W; i++) begin : g_bit_chk
        if (MASK[i]) begin : g_latched
            // R1 R6
            set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> q_o[i]);
            // R3
            clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !q_o[i]);
            // R3
            hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && !set_i[i]) |=> (q_o[i] == $past(q_o[i])));
        end else begin : g_fixed
            // R2 R7
            fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !q_o[i]);
        end
    end
endmodule

// File: rtl/devirq_enable_regs.sv
module devirq_enable_regs
    import devirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en0_i,
    input  logic             wr_en1_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] en0_o,
    output logic [REG_W-1:0] en1_o
);
    en_regs_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_en0_i) en_d.en0 = wdata_i;
        if (wr_en1_i) en_d.en1 = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en0_o = en_q.en0;
    assign en1_o = en_q.en1;

    // R8
    en0_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en0_i |=> (en0_o == $past(wdata_i)));
    // R8
    en1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en1_i |=> (en1_o == $past(en1_o)));
endmodule

// File: rtl/devirq_irq_combine.sv
module devirq_irq_combine #(
    parameter int W = 8
) (
    input  logic [W-1:0] stat0_i,
    input  logic [W-1:0] stat1_i,
    input  logic [W-1:0] en0_i,
    input  logic [W-1:0] en1_i,
    output logic         irq_o
);
    logic [2*W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_hit
        assign hit[i]     = stat0_i[i] & en0_i[i];
        assign hit[W + i] = stat1_i[i] & en1_i[i];
    end

    assign irq_o = |hit;
endmodule

// File: rtl/devirq_ctrl.sv
module devirq_ctrl
    import devirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [EP_W-1:0]   ep_sum_i,
    input  logic              virt_ep_i,
    input  logic              setup_pkt_i,
    input  logic              dma_done_i,
    input  logic              sof_i,
    input  logic              port_rst_chg_i,
    input  logic              resume_i,
    input  logic              susp_chg_i,
    input  logic              vbus_chg_i,
    input  logic              ctl_status_i,
    input  logic              rst_pin_i,
    input  logic              port_rst_active_i,
    input  logic              susp_req_i,
    output logic              irq_o,
    output logic              susp_enter_o
);
    typedef struct packed {
        logic susp_enter;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [REG_W-1:0] set0, set1, clr0, clr1;
    logic [REG_W-1:0] lat0, lat1, live0, live1, stat0, stat1;
    logic [REG_W-1:0] en0, en1;
    logic             wr_s0, wr_s1, wr_e0, wr_e1;

    always_comb begin
        wr_s0 = reg_wr_i && (reg_addr_i == SEL_STAT0);
        wr_s1 = reg_wr_i && (reg_addr_i == SEL_STAT1);
        wr_e0 = reg_wr_i && (reg_addr_i == SEL_EN0);
        wr_e1 = reg_wr_i && (reg_addr_i == SEL_EN1);

        set0 = '0;
        set0[S0_SETUP] = setup_pkt_i;
        set0[S0_DMA]   = dma_done_i;
        set0[S0_SOF]   = sof_i;

        set1 = '0;
        set1[S1_CTL]  = ctl_status_i;
        set1[S1_VBUS] = vbus_chg_i;
        set1[S1_SCHG] = susp_chg_i;
        set1[S1_RES]  = resume_i;
        set1[S1_PRST] = port_rst_chg_i;

        clr0 = wr_s0 ? reg_wdata_i : '0;
        clr1 = wr_s1 ? reg_wdata_i : '0;

        live0 = '0;
        live0[EP_W-1:0] = ep_sum_i;
        live0[S0_VIRT]  = virt_ep_i;

        live1 = '0;
        live1[S1_SUSP] = susp_req_i;
        live1[S1_LIVE] = rst_pin_i | port_rst_active_i;

        ctl_d = ctl_q;
        ctl_d.susp_enter = wr_s1 && reg_wdata_i[S1_SUSP];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    devirq_latch_bank #(.W(REG_W), .MASK(S0_LATCH_MASK)) u_bank0 (
        .clk(clk), .rst_n(rst_n), .set_i(set0), .clr_i(clr0), .q_o(lat0)
    );

    devirq_latch_bank #(.W(REG_W), .MASK(S1_LATCH_MASK)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_i(clr1), .q_o(lat1)
    );

    devirq_enable_regs u_en (
        .clk(clk), .rst_n(rst_n), .wr_en0_i(wr_e0), .wr_en1_i(wr_e1),
        .wdata_i(reg_wdata_i), .en0_o(en0), .en1_o(en1)
    );

    assign stat0 = lat0 | live0;
    assign stat1 = lat1 | live1;

    devirq_irq_combine #(.W(REG_W)) u_irq (
        .stat0_i(stat0), .stat1_i(stat1), .en0_i(en0), .en1_i(en1), .irq_o(irq_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            SEL_STAT0: reg_rdata_o = stat0;
            SEL_STAT1: reg_rdata_o = stat1;
            SEL_EN0:   reg_rdata_o = en0;
            default:   reg_rdata_o = en1;
        endcase
    end

    assign susp_enter_o = ctl_q.susp_enter;

    // R7
    susp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == SEL_STAT1 && reg_wdata_i[S1_SUSP]) |=> susp_enter_o);
    // R7
    susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> !susp_enter_o);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en0 == '0 && en1 == '0) |-> !irq_o);
    // R5
    live_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == SEL_STAT1 && (rst_pin_i || port_rst_active_i)) |-> reg_rdata_o[S1_LIVE]);
endmodule

// File: tb/devirq_ctrl_bench.sv
module devirq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [3:0] ep_sum = 4'd0;
    logic       virt_ep = 1'b0, setup_pkt = 1'b0, dma_done = 1'b0, sof = 1'b0;
    logic       port_rst_chg = 1'b0, resume = 1'b0, susp_chg = 1'b0;
    logic       vbus_chg = 1'b0, ctl_status = 1'b0;
    logic       rst_pin = 1'b0, port_rst_active = 1'b0, susp_req = 1'b0;
    logic       irq, susp_enter;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    devirq_ctrl u_devirq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ep_sum_i(ep_sum),
        .virt_ep_i(virt_ep), .setup_pkt_i(setup_pkt), .dma_done_i(dma_done),
        .sof_i(sof), .port_rst_chg_i(port_rst_chg), .resume_i(resume),
        .susp_chg_i(susp_chg), .vbus_chg_i(vbus_chg), .ctl_status_i(ctl_status),
        .rst_pin_i(rst_pin), .port_rst_active_i(port_rst_active),
        .susp_req_i(susp_req), .irq_o(irq), .susp_enter_o(susp_enter)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    // pulse one event line: 0..2 => status 0 bits 5..7, 3..7 => status 1 bits
    task automatic pulse(input int which, input logic val);
        case (which)
            0: setup_pkt = val;
            1: dma_done = val;
            2: sof = val;
            3: ctl_status = val;
            4: vbus_chg = val;
            5: susp_chg = val;
            6: resume = val;
            default: port_rst_chg = val;
        endcase
    endtask

    function automatic int ev_reg(input int which);
        return (which < 3) ? 0 : 1;
    endfunction

    function automatic int ev_bit(input int which);
        case (which)
            0: return 5;
            1: return 6;
            2: return 7;
            3: return 1;
            4: return 2;
            5: return 4;
            6: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic fire(input int which);
        @(negedge clk);
        pulse(which, 1'b1);
        @(negedge clk);
        pulse(which, 1'b0);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        rd(2'd0, v); chk("R10 stat0", v, 8'h00);
        rd(2'd1, v); chk("R10 stat1", v, 8'h00);
        rd(2'd2, v); chk("R10 en0", v, 8'h00);
        rd(2'd3, v); chk("R10 en1", v, 8'h00);
        chk("R10 irq", {7'd0, irq}, 8'h00);
        chk("R10 susp_enter", {7'd0, susp_enter}, 8'h00);

        // R2 level bits follow inputs; writes ignored
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            ep_sum = p[3:0]; virt_ep = p[4];
            #1;
            rd(2'd0, v); chk("R2 level", v, {3'b000, p[4:0]});
            wr(2'd0, 8'hFF);
            rd(2'd0, v); chk("R2 write ignored", v, {3'b000, p[4:0]});
        end
        ep_sum = 4'd0; virt_ep = 1'b0;

        // R1 R6 R3 R9 latching, enable independence, clear
        for (int e = 0; e < 8; e++) begin
            logic [1:0] sa;
            logic [1:0] ea;
            logic [7:0] m;
            sa = (ev_reg(e) == 0) ? 2'd0 : 2'd1;
            ea = (ev_reg(e) == 0) ? 2'd2 : 2'd3;
            m = 8'd1 << ev_bit(e);
            fire(e);
            rd(sa, v); chk((e < 3) ? "R1 latch" : "R6 latch", v, m);
            chk("R9 masked", {7'd0, irq}, 8'h00);
            wr(ea, m);
            chk("R9 enabled", {7'd0, irq}, 8'h01);
            wr(ea, ~m);
            chk("R9 other enables", {7'd0, irq}, 8'h00);
            wr(sa, ~m);
            rd(sa, v); chk("R3 zero keeps", v, m);
            wr(sa, m);
            rd(sa, v); chk("R3 one clears", v, 8'h00);
            wr(ea, 8'h00);
        end

        // R4 set wins over clear
        @(negedge clk);
        sof = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h80;
        @(negedge clk);
        sof = 1'b0; reg_wr = 1'b0;
        #1;
        rd(2'd0, v); chk("R4 sof kept", v, 8'h80);
        @(negedge clk);
        resume = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hFF;
        @(negedge clk);
        resume = 1'b0; reg_wr = 1'b0;
        #1;
        rd(2'd1, v); chk("R4 resume kept", v, 8'h20);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);

        // R5 live reset bit
        @(negedge clk); rst_pin = 1'b1; #1;
        rd(2'd1, v); chk("R5 pin", v, 8'h80);
        wr(2'd1, 8'h80);
        rd(2'd1, v); chk("R5 not writable", v, 8'h80);
        @(negedge clk); rst_pin = 1'b0; port_rst_active = 1'b1; #1;
        rd(2'd1, v); chk("R5 port reset", v, 8'h80);
        @(negedge clk); port_rst_active = 1'b0; #1;
        rd(2'd1, v); chk("R5 released", v, 8'h00);

        // R7 suspend bit and entry request
        @(negedge clk); susp_req = 1'b1; #1;
        rd(2'd1, v); chk("R7 live susp", v, 8'h08);
        wr(2'd1, 8'h09);
        chk("R7 enter pulse", {7'd0, susp_enter}, 8'h01);
        rd(2'd1, v); chk("R7 bit kept, bit0 zero", v, 8'h08);
        @(negedge clk); #1;
        chk("R7 pulse ends", {7'd0, susp_enter}, 8'h00);
        wr(2'd1, 8'hF7);
        chk("R7 no pulse", {7'd0, susp_enter}, 8'h00);
        @(negedge clk); susp_req = 1'b0; #1;
        rd(2'd1, v); chk("R7 released", v, 8'h00);

        // R8 R9 sweep enable 0 against status 0 = FA
        ep_sum = 4'b1010; virt_ep = 1'b1;
        fire(0); fire(1); fire(2);
        for (int en = 0; en < 256; en++) begin
            wr(2'd2, en[7:0]);
            rd(2'd2, v); chk("R8 en0", v, en[7:0]);
            chk("R9 sweep0", {7'd0, irq}, {7'd0, |(en[7:0] & 8'hFA)});
        end
        wr(2'd2, 8'h00);
        ep_sum = 4'd0; virt_ep = 1'b0;
        wr(2'd0, 8'hFF);

        // R8 R9 sweep enable 1 against status 1 = FE
        rst_pin = 1'b1; susp_req = 1'b1;
        for (int e = 3; e < 8; e++) fire(e);
        for (int en = 0; en < 256; en++) begin
            wr(2'd3, en[7:0]);
            rd(2'd3, v); chk("R8 en1", v, en[7:0]);
            chk("R9 sweep1", {7'd0, irq}, {7'd0, |(en[7:0] & 8'hFE)});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule